// File: doc/BRIEF.md
# Frame Fetch DMA with Watermark Gating

This block pulls a frame buffer out of system memory one word at a time and hands it to a display pipeline that runs on its own pixel clock. On the system-clock side it acts as a bus read master. It walks a read address from a configured base across a configured number of 32-bit words, then starts again at the base. Each word the bus returns is pushed into a dual-clock FIFO. The FIFO shows its head word on its output before the read request (first-word-fall-through).

Two fill watermarks pace the two sides. The fetch side asks for more data only while the FIFO holds less than seven-eighths of its depth. It also caps the number of reads in flight, so that returning words can never overfill the FIFO. The display side waits until the FIFO holds more than half its depth. After that it takes one word on every active pixel. If the FIFO runs dry on an active pixel, the display side sends black and latches an underflow flag. Each watermark flag passes through two flip-flops in the clock domain that consumes it.

Top module: `frame_fetch_dma`

## Requirements
- R1: While rst_ni is low, bus_read_o, pix_data_o and underflow_o are all 0. Releasing reset empties the FIFO, and fetching restarts at the base address.
- R2: The read address equals frame_base_i plus 4 times a word index that starts at 0. The index advances only when bus_read_o is high and bus_waitreq_i is low. After frame_words_i words it wraps to 0.
- R3: Once bus_read_o has been raised with bus_waitreq_i high, bus_read_o stays high and bus_addr_o stays unchanged in the next cycle.
- R4: Every word that arrives with bus_rvalid_i is stored. The words appear on pix_data_o in the order they were returned, so the pixel stream follows the frame buffer word order, wrap included.
- R5: The FIFO fill count plus the number of accepted but unreturned reads never exceeds DEPTH. The FIFO is never written while full.
- R6: New reads are issued only while a flag, registered twice on clk_i, shows the fill count below 7/8 of DEPTH. With the display side idle, fetching settles at no fewer than 7/8 of DEPTH words and no more than DEPTH words.
- R7: The display side stays idle until a flag, registered twice on pix_clk_i, shows the fill count above DEPTH/2. Until then pix_data_o is 0 and no word is consumed. A fill of exactly DEPTH/2 does not start it.
- R8: After start, each cycle with pix_active_i high consumes one word, and that word appears on pix_data_o one pix_clk_i cycle later. A cycle with pix_active_i low produces 0 one cycle later.
- R9: After start, an active pixel that meets an empty FIFO produces 0 and sets underflow_o. underflow_o stays at 1 until reset, and later words continue the sequence without a gap.
- R10: The FIFO is 32 bits wide and shows its head word without an extra read cycle. The low-active reset clears it asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (bus side, FIFO write side) |
| pix_clk_i | input | 1 | Pixel clock (FIFO read side) |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| frame_base_i | input | ADDR_W | Byte address of the first frame word |
| frame_words_i | input | LEN_W | Frame length in 32-bit words |
| bus_addr_o | output | ADDR_W | Read byte address |
| bus_read_o | output | 1 | Read request |
| bus_waitreq_i | input | 1 | Slave stall; the request is accepted when low |
| bus_rdata_i | input | 32 | Returned read data |
| bus_rvalid_i | input | 1 | Returned data valid |
| pix_active_i | input | 1 | Active-pixel strobe from the raster timing |
| pix_data_o | output | 32 | Pixel word, 0 when blank, idle or starved |
| underflow_o | output | 1 | Sticky FIFO-starvation flag |

## Verification
The case most likely to go wrong is a read being accepted in the same clock edge as an earlier read's data returning. The in-flight count then goes up and down at once while the fill count rises. The bench provokes this with random stalls and random return latency of one to four cycles. With the display idle, it judges the result by requiring the total accepted reads to settle between 7/8 of DEPTH and DEPTH, with every read returned. It then runs a long wrapping stream and requires every pixel word, and every accepted address, to match the expected frame order.

// File: rtl/ffd_pkg.sv
`timescale 1ns/1ps
package ffd_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic int room_mark(input int depth);
    return depth * 7 / 8;
  endfunction

  function automatic int data_mark(input int depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/ffd_sync2.sv
`timescale 1ns/1ps
module ffd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ffd_async_fifo.sv
`timescale 1ns/1ps
module ffd_async_fifo
  import ffd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  word_t         wdata_i,
  output logic [PW-1:0] wused_o,
  input  logic          re_i,
  output word_t         rdata_o,
  output logic          rempty_o,
  output logic [PW-1:0] rused_o
);
  word_t mem [DEPTH];

  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r;
  logic          wfull;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  ffd_sync2 #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w));
  ffd_sync2 #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r));

  // write side
  assign wused_o = wbin_q - g2b(rgray_w);
  assign wfull   = (wused_o == PW'(DEPTH));

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_i && !wfull) begin
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= b2g(wbin_q + 1'b1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (we_i && !wfull) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  // read side, head word shown ahead of the request
  assign rdata_o  = mem[rbin_q[AW-1:0]];
  assign rempty_o = (rgray_q == wgray_r);
  assign rused_o  = g2b(wgray_r) - rbin_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (re_i && !rempty_o) begin
      rbin_q  <= rbin_q + 1'b1;
      rgray_q <= b2g(rbin_q + 1'b1);
    end
  end

  // R5: a returned word must always find a free slot
  a_r5_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |-> !wfull);
  // R10: the reader never pops an empty FIFO
  a_r10_no_empty_pop: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    re_i |-> !rempty_o);
  // R5: the reported fill never goes past the depth
  a_r5_fill_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wused_o <= PW'(DEPTH));
endmodule

// File: rtl/ffd_fetch.sv
`timescale 1ns/1ps
module ffd_fetch
  import ffd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PW-1:0]     fill_i,
  input  logic              waitreq_i,
  input  logic              rvalid_i,
  output logic              read_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [PW-1:0] ROOM_MARK = PW'(room_mark(DEPTH));
  localparam logic [PW:0]   DEPTH_W   = (PW+1)'(DEPTH);

  logic             room_raw, room_q;
  logic             pend_q, can_issue, accept;
  logic [LEN_W-1:0] idx_q;
  logic [PW-1:0]    inflight_q;
  logic [PW:0]      budget_sum;
  logic             last_word;

  assign room_raw = (fill_i < ROOM_MARK);

  ffd_sync2 #(.W(1)) u_room (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(room_raw), .q_o(room_q));

  // fill plus in-flight reads bounds what can still land in the FIFO
  assign budget_sum = {1'b0, fill_i} + {1'b0, inflight_q};
  assign can_issue  = room_q && (budget_sum < DEPTH_W);
  assign read_o     = pend_q | can_issue;
  assign accept     = read_o & ~waitreq_i;
  assign addr_o     = base_i + (ADDR_W'(idx_q) << 2);
  assign last_word  = ({1'b0, idx_q} + 1'b1) >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      idx_q      <= '0;
      inflight_q <= '0;
    end else begin
      pend_q <= read_o & waitreq_i;
      if (accept) idx_q <= last_word ? '0 : idx_q + 1'b1;
      unique case ({accept, rvalid_i})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  a_r3_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_o && waitreq_i) |=> (read_o && $stable(addr_o)));
  a_r5_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    budget_sum <= DEPTH_W);
  a_r2_index_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(idx_q));
  a_r6_no_issue_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!room_q && !pend_q) |-> !read_o);
endmodule

// File: rtl/ffd_drain.sv
`timescale 1ns/1ps
module ffd_drain
  import ffd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [PW-1:0] fill_i,
  input  logic          empty_i,
  input  word_t         head_i,
  output logic          pop_o,
  output word_t         pix_o,
  output logic          underflow_o
);
  localparam logic [PW-1:0] DATA_MARK = PW'(data_mark(DEPTH));

  logic data_raw, data_q, started_q;

  assign data_raw = (fill_i > DATA_MARK);

  ffd_sync2 #(.W(1)) u_data (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_raw), .q_o(data_q));

  assign pop_o = active_i & started_q & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      pix_o       <= '0;
      underflow_o <= 1'b0;
    end else begin
      started_q   <= started_q | data_q;
      pix_o       <= pop_o ? head_i : '0;
      underflow_o <= underflow_o | (active_i & started_q & empty_i);
    end
  end

  a_r9_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  a_r8_blank_is_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (pix_o == '0));
  a_r9_starved_is_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && empty_i) |=> (pix_o == '0));
  a_r7_idle_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |=> (pix_o == '0));
endmodule

// File: rtl/frame_fetch_dma.sv
`timescale 1ns/1ps
module frame_fetch_dma
  import ffd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] frame_base_i,
  input  logic [LEN_W-1:0]  frame_words_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  input  logic              bus_waitreq_i,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_rvalid_i,
  input  logic              pix_active_i,
  output logic [31:0]       pix_data_o,
  output logic              underflow_o
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic [PW-1:0] wused, rused;
  logic          rempty, pop;
  word_t         head;

  ffd_fetch #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_i    (frame_base_i),
    .len_i     (frame_words_i),
    .fill_i    (wused),
    .waitreq_i (bus_waitreq_i),
    .rvalid_i  (bus_rvalid_i),
    .read_o    (bus_read_o),
    .addr_o    (bus_addr_o)
  );

  ffd_async_fifo #(.DEPTH(DEPTH)) u_fifo (
    .wclk_i   (clk_i),
    .rclk_i   (pix_clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_rvalid_i),
    .wdata_i  (bus_rdata_i),
    .wused_o  (wused),
    .re_i     (pop),
    .rdata_o  (head),
    .rempty_o (rempty),
    .rused_o  (rused)
  );

  ffd_drain #(.DEPTH(DEPTH)) u_drain (
    .clk_i       (pix_clk_i),
    .rst_ni      (rst_ni),
    .active_i    (pix_active_i),
    .fill_i      (rused),
    .empty_i     (rempty),
    .head_i      (head),
    .pop_o       (pop),
    .pix_o       (pix_data_o),
    .underflow_o (underflow_o)
  );
endmodule

// File: tb/sim_frame_fetch_dma.sv
`timescale 1ns/1ps
module sim_frame_fetch_dma;
  localparam int DEPTH = 16;

  logic        clk_i = 0, pix_clk_i = 0, rst_ni = 0;
  logic [31:0] frame_base_i = 32'h0;
  logic [19:0] frame_words_i = 20'd16;
  logic [31:0] bus_addr_o;
  logic        bus_read_o;
  logic        bus_waitreq_i = 0;
  logic [31:0] bus_rdata_i = 0;
  logic        bus_rvalid_i = 0;
  logic        pix_active_i = 0;
  logic [31:0] pix_data_o;
  logic        underflow_o;

  always #10 clk_i = ~clk_i;      // 50 MHz
  always #15 pix_clk_i = ~pix_clk_i;

  frame_fetch_dma #(.DEPTH(DEPTH)) u0 (.*);

  int total = 0, fails = 0;
  int wait_pct = 0, budget = -1, act_mode = 0;
  int cyc = 0, pcyc = 0;
  int acc_cnt = 0, ret_cnt = 0, addr_errs = 0, hs_errs = 0;
  int pix_words = 0, pix_errs = 0, inact_errs = 0;
  logic        stall_prev = 0;
  logic [31:0] stall_addr = 0;
  logic [31:0] q_addr[$];
  int          q_rdy[$];

  function automatic logic [31:0] sig(input logic [31:0] a);
    return {8'hC3, a[23:0]};
  endfunction

  function automatic logic [31:0] exp_addr(input int k);
    return frame_base_i + 32'(4 * (k % int'(frame_words_i)));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus slave model: decisions at the falling edge, taken at the next rising edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      q_addr.delete(); q_rdy.delete();
      bus_waitreq_i = 0; bus_rvalid_i = 0; stall_prev = 0;
      acc_cnt = 0; ret_cnt = 0; addr_errs = 0; hs_errs = 0; cyc = 0;
    end else begin
      cyc++;
      if (stall_prev && !(bus_read_o && bus_addr_o == stall_addr)) hs_errs++;
      bus_waitreq_i = (int'($urandom % 100) < wait_pct);
      stall_prev = bus_read_o && bus_waitreq_i;
      stall_addr = bus_addr_o;
      if (bus_read_o && !bus_waitreq_i) begin
        if (bus_addr_o != exp_addr(acc_cnt)) addr_errs++;
        acc_cnt++;
        q_addr.push_back(bus_addr_o);
        q_rdy.push_back(cyc + 1 + int'($urandom % 4));
      end
      bus_rvalid_i = 0;
      if (q_addr.size() > 0 && q_rdy[0] <= cyc && budget != 0) begin
        bus_rvalid_i = 1;
        bus_rdata_i  = sig(q_addr.pop_front());
        void'(q_rdy.pop_front());
        ret_cnt++;
        if (budget > 0) budget--;
      end
    end
  end

  // pixel-side monitor and active-strobe driver
  always @(negedge pix_clk_i) begin
    if (!rst_ni) begin
      pix_words = 0; pix_errs = 0; inact_errs = 0; pcyc = 0;
      pix_active_i = 0;
    end else begin
      if (pix_data_o != 0) begin
        if (!pix_active_i) inact_errs++;
        if (pix_data_o != sig(exp_addr(pix_words))) begin
          pix_errs++;
          if (pix_errs == 1)
            $display("  first pixel mismatch at word %0d: %0h vs %0h",
                     pix_words, pix_data_o, sig(exp_addr(pix_words)));
        end
        pix_words++;
      end
      pcyc++;
      case (act_mode)
        1:       pix_active_i = 1;
        2:       pix_active_i = ((pcyc % 4) < 2);
        default: pix_active_i = 0;
      endcase
    end
  end

  task automatic do_reset(input logic [31:0] base, input int words);
    @(negedge clk_i);
    rst_ni = 0;
    frame_base_i = base;
    frame_words_i = 20'(words);
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic t_reset();
    do_reset(32'h0, 16);
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check(bus_read_o == 0, "R1", "read in reset", bus_read_o, 0);
    check(pix_data_o == 0, "R1", "pixel in reset", pix_data_o, 0);
    check(underflow_o == 0, "R1", "underflow in reset", underflow_o, 0);
    rst_ni = 1;
  endtask

  task automatic t_start_watermark();
    act_mode = 1; wait_pct = 0; budget = 0;
    do_reset(32'h2000, 64);
    repeat (100) @(negedge clk_i);
    check(pix_words == 0, "R7", "output before any data", pix_words, 0);
    budget = 8;
    repeat (200) @(negedge clk_i);
    check(pix_words == 0, "R7", "start at exactly half", pix_words, 0);
    check(underflow_o == 0, "R7", "no underflow while idle", underflow_o, 0);
    budget = 1;
    repeat (200) @(negedge clk_i);
    check(pix_words == 9, "R8", "words drained after start", pix_words, 9);
    check(pix_errs == 0, "R4", "drained word order", pix_errs, 0);
    check(underflow_o == 1, "R9", "underflow on empty", underflow_o, 1);
    budget = -1;
    repeat (400) @(negedge clk_i);
    check(underflow_o == 1, "R9", "underflow sticky", underflow_o, 1);
    check(pix_words > 9, "R9", "stream resumes", pix_words, 10);
    check(pix_errs == 0, "R9", "no gap after underflow", pix_errs, 0);
  endtask

  task automatic t_fill_limit();
    act_mode = 0; wait_pct = 30; budget = -1;
    do_reset(32'h0, 40);
    repeat (400) @(negedge clk_i);
    check(acc_cnt <= DEPTH, "R5", "reads accepted bound", acc_cnt, DEPTH);
    check(acc_cnt >= DEPTH * 7 / 8, "R6", "reads fetched up to mark", acc_cnt, DEPTH * 7 / 8);
    check(ret_cnt == acc_cnt, "R4", "all reads returned", ret_cnt, acc_cnt);
    check(pix_words == 0, "R8", "no pixels while inactive", pix_words, 0);
    check(addr_errs == 0, "R2", "linear addresses", addr_errs, 0);
  endtask

  task automatic t_stream();
    act_mode = 2; wait_pct = 25; budget = -1;
    do_reset(32'h1000, 6);
    repeat (3000) @(negedge clk_i);
    check(pix_words >= 100, "R8", "stream throughput", pix_words, 100);
    check(pix_errs == 0, "R4", "wrapped pixel order", pix_errs, 0);
    check(addr_errs == 0, "R2", "wrapped address order", addr_errs, 0);
    check(hs_errs == 0, "R3", "request held under stall", hs_errs, 0);
    check(inact_errs == 0, "R8", "black outside active", inact_errs, 0);
    check(underflow_o == 0, "R9", "no underflow when fed", underflow_o, 0);
  endtask

  task automatic t_mid_reset();
    act_mode = 2; wait_pct = 10; budget = -1;
    repeat (300) @(negedge clk_i);
    rst_ni = 0;
    frame_base_i = 32'h300;
    frame_words_i = 20'd5;
    repeat (3) @(negedge clk_i);
    check(bus_read_o == 0, "R1", "read during mid reset", bus_read_o, 0);
    check(pix_data_o == 0, "R1", "pixel during mid reset", pix_data_o, 0);
    rst_ni = 1;
    repeat (1500) @(negedge clk_i);
    check(pix_words > 20, "R10", "stream after clear", pix_words, 21);
    check(pix_errs == 0, "R10", "old data flushed, restart at base", pix_errs, 0);
    check(addr_errs == 0, "R1", "fetch restarts at base", addr_errs, 0);
  endtask

  initial begin
    t_reset();
    t_start_watermark();
    t_fill_limit();
    t_stream();
    t_mid_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule